// File: doc/BRIEF.md
# Pulse-Swallow Programmable Feedback Divider

This block divides a fast input clock down to a feedback pulse for a phase comparator in a frequency synthesiser loop. It uses a dual-modulus counter of the M·N+A kind with N fixed at 16. A 13-bit M value and a 4-bit A value give a 17-bit division ratio of 16·M + A. An optional divide-by-two front stage can be placed ahead of the programmable counter. When it is enabled, every ratio is doubled in input clock cycles.

New M and A values arrive with a load strobe. They are cleaned up and held in shadow registers, then moved into the active counters only on the edge that ends the current divide cycle. A cycle in progress always runs to completion on its old ratio, so retuning never yields a short or long stray period. Out-of-range ratios are forced into range, and a flag reports this. Besides the one-clock pulse, a further halved square copy of the output is provided for observation on a test pin.

Top module: `pswallow_divider`

## Requirements
- R1: While reset is high and on the first cycle after it, div_pulse, div_half and ratio_err are 0. Reset makes the active ratio M=1, A=0, so with the front stage off the first pulse appears 16 cycles after reset is released.
- R2: With pre_en=0 and 0 ≤ A ≤ M, M ≥ 1, consecutive rising edges of div_pulse are exactly 16·M + A input clock cycles apart.
- R3: With pre_en=1, held constant since reset, consecutive pulses are 2·(16·M + A) input clock cycles apart.
- R4: div_pulse is high for exactly one input clock cycle per divide cycle.
- R5: A value taken by load does not change the divide cycle in progress. It governs the cycle that starts at the next pulse.
- R6: When several loads occur within one divide cycle, only the last one takes effect at the boundary.
- R7: A load with A > M is applied as A = M. ratio_err is 1 from the cycle after such a load. A later valid load clears ratio_err on the cycle after that load.
- R8: A load with M = 0 is applied as M = 1, with A limited to at most 1, and it sets ratio_err in the same way as R7.
- R9: div_half toggles on the same edge on which each div_pulse rises. It is 1 at the first pulse after reset, so it is a square wave at half the pulse rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| pre_en | input | 1 | 1 puts the divide-by-two stage ahead of the counter; static |
| m_in | input | 13 | Requested M (count of 16/17 sub-cycles) |
| a_in | input | 4 | Requested A (count of 17-length sub-cycles) |
| load | input | 1 | Captures m_in and a_in into the shadow registers |
| div_pulse | output | 1 | One-clock pulse at each terminal count |
| div_half | output | 1 | Toggles at each pulse, for test observation |
| ratio_err | output | 1 | Last loaded ratio was out of range and was forced into range |

## Verification
The properties assume that pre_en changes only while rst is high. A running change of the front stage may stretch or shorten the boundary period, and neither the design nor the checks define that period. The bench therefore sets pre_en only inside a reset pulse, never alters it while the divider runs, and measures only intervals that start after a completed boundary. Load strobes are one cycle wide and are driven away from the clock edge. Illegal ratios enter only through m_in and a_in, so the forcing into range and the flag are exercised at the ports.

// File: rtl/psd_pkg.sv
package psd_pkg;
  localparam int unsigned PSD_M_W = 13;
  localparam int unsigned PSD_A_W = 4;

  typedef enum logic {
    FRONT_BYPASS = 1'b0,
    FRONT_HALVE  = 1'b1
  } front_mode_e;
endpackage

// File: rtl/psd_front_stage.sv
module psd_front_stage
  import psd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic pre_en,
  output logic tick
);
  logic        phase_q;
  front_mode_e mode;

  assign mode = front_mode_e'(pre_en);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= 1'b0;
    end else if (mode == FRONT_HALVE) begin
      phase_q <= ~phase_q;
    end else begin
      phase_q <= 1'b0;
    end
  end

  assign tick = (mode == FRONT_HALVE) ? phase_q : 1'b1;

  // R3: with the halving stage on, ticks never come back to back
  a_r3_tick_alternates: assert property (@(posedge clk) disable iff (rst)
    (pre_en && tick) |=> (!tick || !pre_en));
endmodule

// File: rtl/psd_ratio_regs.sv
module psd_ratio_regs #(
  parameter int unsigned M_W = 13,
  parameter int unsigned A_W = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [M_W-1:0] m_in,
  input  logic [A_W-1:0] a_in,
  input  logic           term,
  output logic [M_W-1:0] act_m,
  output logic [A_W-1:0] act_a,
  output logic [A_W-1:0] nxt_a,
  output logic           ratio_err
);
  logic [M_W-1:0] m_fix;
  logic [A_W-1:0] a_fix;
  logic [M_W-1:0] a_wide;
  logic           bad;
  logic [M_W-1:0] sh_m;
  logic [A_W-1:0] sh_a;
  logic           pend;

  // clean up the request: M at least 1, A no larger than M
  always_comb begin
    a_wide = M_W'(a_in);
    m_fix  = (m_in == '0) ? M_W'(1) : m_in;
    a_fix  = (a_wide > m_fix) ? A_W'(m_fix) : a_in;
    bad    = (m_in == '0) || (a_wide > m_in);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_m      <= M_W'(1);
      sh_a      <= '0;
      pend      <= 1'b0;
      ratio_err <= 1'b0;
    end else if (load) begin
      sh_m      <= m_fix;
      sh_a      <= a_fix;
      pend      <= 1'b1;
      ratio_err <= bad;
    end else if (term) begin
      pend      <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_m <= M_W'(1);
      act_a <= '0;
    end else if (term && pend) begin
      act_m <= sh_m;
      act_a <= sh_a;
    end
  end

  assign nxt_a = pend ? sh_a : act_a;

  // R5: the active ratio moves only on a divide-cycle boundary
  a_r5_hold_midcycle: assert property (@(posedge clk) disable iff (rst)
    !term |=> ($stable(act_m) && $stable(act_a)));

  // R7, R8: the active ratio is always legal
  a_r7_active_legal: assert property (@(posedge clk) disable iff (rst)
    (M_W'(act_a) <= act_m) && (act_m != '0));

  // R7: a load requesting A above M raises the flag
  a_r7_flag_on_excess: assert property (@(posedge clk) disable iff (rst)
    (load && (M_W'(a_in) > m_in)) |=> ratio_err);
endmodule

// File: rtl/psd_swallow_ctr.sv
module psd_swallow_ctr #(
  parameter int unsigned M_W = 13,
  parameter int unsigned A_W = 4,
  parameter int unsigned N   = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick,
  input  logic [M_W-1:0] act_m,
  input  logic [A_W-1:0] nxt_a,
  output logic           term
);
  localparam int unsigned MC_W = $clog2(N + 1);

  logic [MC_W-1:0] mc_q;
  logic [M_W-1:0]  sc_q;
  logic [A_W-1:0]  ac_q;
  logic            swallow;
  logic            sub_end;
  logic            last_sub;

  always_comb begin
    swallow  = (ac_q != '0);
    sub_end  = swallow ? (mc_q == MC_W'(N)) : (mc_q == MC_W'(N - 1));
    last_sub = (sc_q == act_m - 1'b1);
    term     = tick & sub_end & last_sub;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mc_q <= '0;
      sc_q <= '0;
      ac_q <= '0;
    end else if (tick) begin
      if (sub_end) begin
        mc_q <= '0;
        if (last_sub) begin
          sc_q <= '0;
          ac_q <= nxt_a;
        end else begin
          sc_q <= sc_q + 1'b1;
          if (swallow) ac_q <= ac_q - 1'b1;
        end
      end else begin
        mc_q <= mc_q + 1'b1;
      end
    end
  end

  // R2: the modulus counter never passes N
  a_r2_mod_range: assert property (@(posedge clk) disable iff (rst)
    mc_q <= MC_W'(N));

  // R2: the sub-cycle index stays below the active M
  a_r2_sub_range: assert property (@(posedge clk) disable iff (rst)
    sc_q < act_m);

  // R2: swallows left never exceed sub-cycles left
  a_r2_swallow_fits: assert property (@(posedge clk) disable iff (rst)
    M_W'(ac_q) <= (act_m - sc_q));
endmodule

// File: rtl/pswallow_divider.sv
module pswallow_divider #(
  parameter int unsigned M_W = psd_pkg::PSD_M_W,
  parameter int unsigned A_W = psd_pkg::PSD_A_W,
  parameter int unsigned N   = 1 << A_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           pre_en,
  input  logic [M_W-1:0] m_in,
  input  logic [A_W-1:0] a_in,
  input  logic           load,
  output logic           div_pulse,
  output logic           div_half,
  output logic           ratio_err
);
  logic           tick;
  logic           term;
  logic [M_W-1:0] act_m;
  logic [A_W-1:0] act_a;
  logic [A_W-1:0] nxt_a;

  psd_front_stage u_front (
    .clk    (clk),
    .rst    (rst),
    .pre_en (pre_en),
    .tick   (tick)
  );

  psd_ratio_regs #(.M_W(M_W), .A_W(A_W)) u_ratio (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .m_in      (m_in),
    .a_in      (a_in),
    .term      (term),
    .act_m     (act_m),
    .act_a     (act_a),
    .nxt_a     (nxt_a),
    .ratio_err (ratio_err)
  );

  psd_swallow_ctr #(.M_W(M_W), .A_W(A_W), .N(N)) u_ctr (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick),
    .act_m (act_m),
    .nxt_a (nxt_a),
    .term  (term)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      div_pulse <= 1'b0;
      div_half  <= 1'b0;
    end else begin
      div_pulse <= term;
      div_half  <= div_half ^ term;
    end
  end

  // R1: outputs are clear right after a reset cycle
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!div_pulse && !div_half && !ratio_err));

  // R4: the pulse is one clock wide
  a_r4_one_wide: assert property (@(posedge clk) disable iff (rst)
    div_pulse |=> !div_pulse);

  // R9: the test copy flips together with each pulse
  a_r9_half_flip: assert property (@(posedge clk) disable iff (rst)
    div_pulse |-> (div_half != $past(div_half)));

  // R9: the test copy holds between pulses
  a_r9_half_hold: assert property (@(posedge clk) disable iff (rst)
    !div_pulse |-> $stable(div_half));
endmodule

// File: tb/sim_pswallow_divider.sv
module sim_pswallow_divider;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pre_en = 1'b0;
  logic [12:0] m_in = '0;
  logic [3:0]  a_in = '0;
  logic        load = 1'b0;
  logic        div_pulse;
  logic        div_half;
  logic        ratio_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pswallow_divider u0 (
    .clk(clk), .rst(rst), .pre_en(pre_en), .m_in(m_in), .a_in(a_in),
    .load(load), .div_pulse(div_pulse), .div_half(div_half),
    .ratio_err(ratio_err)
  );

  // {pre[32], m[31:19], a[18:15], err[14], interval[13:0]}
  localparam int NV = 11;
  localparam logic [32:0] VEC [NV] = '{
    {1'b0, 13'd1,   4'd0,  1'b0, 14'd16},
    {1'b0, 13'd1,   4'd1,  1'b0, 14'd17},
    {1'b0, 13'd5,   4'd3,  1'b0, 14'd83},
    {1'b0, 13'd20,  4'd15, 1'b0, 14'd335},
    {1'b0, 13'd16,  4'd0,  1'b0, 14'd256},
    {1'b1, 13'd1,   4'd0,  1'b0, 14'd32},
    {1'b1, 13'd3,   4'd2,  1'b0, 14'd100},
    {1'b1, 13'd10,  4'd7,  1'b0, 14'd334},
    {1'b0, 13'd2,   4'd9,  1'b1, 14'd34},
    {1'b0, 13'd0,   4'd4,  1'b1, 14'd17},
    {1'b0, 13'd100, 4'd15, 1'b0, 14'd1615}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic pre);
    rst = 1'b1;
    pre_en = pre;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic do_load(input logic [12:0] m, input logic [3:0] a);
    m_in = m;
    a_in = a;
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  // returns the number of negedges until div_pulse is seen high
  task automatic wait_pulse(output int n);
    n = 0;
    forever begin
      @(negedge clk);
      n++;
      if (div_pulse) break;
      if (n > 5000) begin
        check(1'b0, "watchdog-pulse", n, 0);
        break;
      end
    end
  endtask

  initial begin
    repeat (150000) @(negedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    int n2;
    // R1: reset state and default ratio
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(!div_pulse && !div_half && !ratio_err, "R1 in reset", {div_pulse, div_half, ratio_err}, 0);
    do_reset(1'b0);
    check(!div_pulse && !div_half && !ratio_err, "R1 after release", {div_pulse, div_half, ratio_err}, 0);
    wait_pulse(n);
    check(n == 16, "R1 first pulse", n, 16);
    check(div_half == 1'b1, "R9 half at first pulse", div_half, 1);
    @(negedge clk);
    check(div_pulse == 1'b0, "R4 pulse width", div_pulse, 0);
    wait_pulse(n);
    check(n == 15, "R2 default interval", n + 1, 16);
    check(div_half == 1'b0, "R9 half at second pulse", div_half, 0);

    // table walk: R2, R3, R7, R8
    for (int i = 0; i < NV; i++) begin
      logic [32:0] v;
      v = VEC[i];
      do_reset(v[32]);
      do_load(v[31:19], v[18:15]);
      check(ratio_err == v[14], "R7/R8 flag", ratio_err, v[14]);
      wait_pulse(n);
      wait_pulse(n);
      check(n == int'(v[13:0]), v[32] ? "R3 interval" : "R2/R7/R8 interval", n, int'(v[13:0]));
    end

    // R7: a valid load clears the flag
    do_reset(1'b0);
    do_load(13'd2, 4'd9);
    check(ratio_err == 1'b1, "R7 set", ratio_err, 1);
    do_load(13'd1, 4'd0);
    check(ratio_err == 1'b0, "R7 clear", ratio_err, 0);

    // R5: mid-cycle load leaves the running cycle alone
    do_reset(1'b0);
    do_load(13'd4, 4'd0);
    wait_pulse(n);
    wait_pulse(n);
    check(n == 64, "R5 base interval", n, 64);
    repeat (10) @(negedge clk);
    do_load(13'd2, 4'd1);
    wait_pulse(n2);
    check(n2 + 11 == 64, "R5 running cycle kept", n2 + 11, 64);
    wait_pulse(n);
    check(n == 33, "R5 new ratio applied", n, 33);

    // R6: last of several loads wins
    do_load(13'd5, 4'd5);
    do_load(13'd2, 4'd0);
    wait_pulse(n2);
    check(n2 + 2 == 33, "R6 running cycle kept", n2 + 2, 33);
    wait_pulse(n);
    check(n == 32, "R6 last load wins", n, 32);
    wait_pulse(n);
    check(n == 32, "R6 ratio persists", n, 32);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule